// File: doc/BRIEF.md
# Serial-Bus Register Target for a Seconds Counter

This block is the two-wire serial bus (I2C) target that sits in front of a 32-bit seconds counter. It runs from a system clock that oversamples the bus lines, recognises START and STOP, answers one fixed 7-bit device address, and gives a bus master burst access to a six-entry register space. That space holds the four counter bytes (owned by a separate counter block and reached through a small byte-write bus), a control byte whose top bit stops the oscillator during backup operation, and a charger configuration byte that is decoded into enable, diode and resistor selections for an analog charger.

A write transaction sets the register pointer and then stores any number of bytes at successive locations. A read transaction returns bytes from wherever the pointer was left, so a master can set the pointer once and read the same location again later. The pointer runs through the six locations and returns to the first. An access-inhibit input, driven by the supply monitor, makes the target deaf and silent on the bus while the supply is out of tolerance.

Top module: `sercnt_regif`

## Requirements
- R1: The target answers only the address 7'b1101000 (first byte D0h selects a write, D1h a read) by pulling SDA low in the acknowledge slot; any other address gets no acknowledge and the target drives nothing until the next START.
- R2: In a write, the first byte after the address loads the register pointer; each later byte is stored at the pointer, the pointer then advances, and every byte is acknowledged.
- R3: A read returns bytes starting at the pointer left by the last transfer, one per byte slot while the master acknowledges; after the master's NACK the target releases SDA and leaves it released until the next START.
- R4: The pointer advances from 05h to 00h; a pointer byte above 05h loads the pointer with 00h.
- R5: START (SDA falling while SCL high) restarts address reception at any point, including in the middle of a byte, and the partial byte has no effect; STOP (SDA rising while SCL high) returns the target to idle.
- R6: While the inhibit input is high the target drives no acknowledge or data and performs no register write.
- R7: The charger enable output is 1 only when the charger byte (location 05h) has bits 7:4 = 1010, bits 3:2 = 01 or 10, and bits 1:0 other than 00.
- R8: When charging is enabled, the diode output is 1 for bits 3:2 = 10 and 0 for 01, and the resistor select output equals bits 1:0 (01, 10, 11 for the low, middle and high resistor); when disabled both are 0. Control and charger bytes reset to 00h.
- R9: Locations 00h..03h are the counter bytes, least significant first; a write to one of them gives a one-cycle counter write strobe with that byte index and data, and a read returns that byte of the counter value input.
- R10: Location 04h is a read/write control byte whose bit 7 drives the oscillator-stop output.
- R11: The target changes its SDA drive only while SCL is low, except when it releases the line because of inhibit, START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16 cycles per fast-mode bit |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level, asynchronous |
| sda_in | input | 1 | Bus data line level, asynchronous |
| inhibit | input | 1 | Supply out of tolerance; target ignores the bus |
| cnt_value | input | 32 | Current counter value from the counter block |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain drive) |
| cnt_we | output | 1 | One-cycle strobe writing a counter byte |
| cnt_sel | output | 2 | Counter byte index for the strobe (0 = least significant) |
| cnt_wdata | output | 8 | Byte written to the counter |
| osc_stop | output | 1 | Control bit 7: stop oscillator in backup |
| chg_en | output | 1 | Charger enabled by a valid configuration |
| chg_diode | output | 1 | Series diode selected |
| chg_res | output | 2 | Resistor selection, 00 when disabled |

## Verification
Assertions watch on every cycle that SDA drive moves only while SCL is low, that inhibit silences the drive and the write strobe, that the pointer never leaves the six-entry range and wraps from the last location, and that the charger outputs never move without a write to the charger byte. Address matching, burst ordering, pointer retention between transactions, abort by a repeated START, the NACK release and the full charger decode depend on whole bus sequences, so only the bench scenarios show them, by driving a modelled master and comparing acknowledges, read bytes and counter writes with values worked out from the requirements.

// File: rtl/sercnt_pkg.sv
package sercnt_pkg;

    localparam int REG_COUNT = 6;
    localparam int PTR_W     = 3;
    localparam int CNT_BYTES = 4;

    localparam logic [PTR_W-1:0] IDX_CTRL = PTR_W'(CNT_BYTES);
    localparam logic [PTR_W-1:0] IDX_TRK  = PTR_W'(REG_COUNT - 1);

    localparam logic [6:0] DEV_ADDR = 7'b1101000;
    localparam logic [3:0] CHG_KEY  = 4'b1010;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_PTR,
        PH_WDATA,
        PH_RDATA
    } phase_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_evt_t;

    typedef struct packed {
        logic       en;
        logic       diode;
        logic [1:0] res;
    } chg_cfg_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p >= IDX_TRK) ? '0 : p + 1'b1;
    endfunction

    function automatic chg_cfg_t chg_decode(input logic [7:0] b);
        chg_cfg_t c;
        logic ds_ok;
        ds_ok   = (b[3:2] == 2'b01) || (b[3:2] == 2'b10);
        c.en    = (b[7:4] == CHG_KEY) && ds_ok && (b[1:0] != 2'b00);
        c.diode = c.en && (b[3:2] == 2'b10);
        c.res   = c.en ? b[1:0] : 2'b00;
        return c;
    endfunction

endpackage

// File: rtl/sercnt_sync.sv
module sercnt_sync
    import sercnt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_raw,
    input  logic     sda_raw,
    output bus_evt_t evt
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_d;
    logic              sda_d;
    logic              scl_s;
    logic              sda_s;

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    always_comb begin
        evt.scl      = scl_s;
        evt.sda      = sda_s;
        evt.scl_rise = scl_s & ~scl_d;
        evt.scl_fall = ~scl_s & scl_d;
        evt.start    = scl_s & scl_d & sda_d & ~sda_s;
        evt.stop     = scl_s & scl_d & ~sda_d & sda_s;
    end

endmodule

// File: rtl/sercnt_proto.sv
module sercnt_proto
    import sercnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  bus_evt_t         evt,
    input  logic             inhibit,
    input  logic [7:0]       rd_byte,
    output logic [PTR_W-1:0] ptr,
    output logic             wr_stb,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data,
    output logic             sda_pull
);

    phase_e     phase;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txbyte;
    logic       mack;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txbyte   <= '0;
            mack     <= 1'b0;
            ptr      <= '0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else if (inhibit) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            sda_pull <= 1'b0;
            wr_stb   <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            if (evt.start) begin
                phase    <= PH_ADDR;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (evt.stop) begin
                phase    <= PH_IDLE;
                bitcnt   <= '0;
                sda_pull <= 1'b0;
            end else if (phase != PH_IDLE) begin
                if (evt.scl_rise) begin
                    if (bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], evt.sda};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (bitcnt == 4'd8) begin
                        mack   <= ~evt.sda;
                        bitcnt <= 4'd9;
                    end
                end else if (evt.scl_fall) begin
                    if (bitcnt == 4'd8) begin
                        case (phase)
                            PH_ADDR: begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    phase    <= shreg[0] ? PH_RDATA : PH_PTR;
                                end else begin
                                    phase <= PH_IDLE;
                                end
                            end
                            PH_PTR: begin
                                ptr      <= (shreg < 8'(REG_COUNT)) ? shreg[PTR_W-1:0] : '0;
                                sda_pull <= 1'b1;
                                phase    <= PH_WDATA;
                            end
                            PH_WDATA: begin
                                wr_stb   <= 1'b1;
                                wr_addr  <= ptr;
                                wr_data  <= shreg;
                                ptr      <= ptr_next(ptr);
                                sda_pull <= 1'b1;
                            end
                            PH_RDATA: begin
                                sda_pull <= 1'b0;
                                ptr      <= ptr_next(ptr);
                            end
                            default: phase <= PH_IDLE;
                        endcase
                    end else if (bitcnt == 4'd9) begin
                        bitcnt <= '0;
                        if (phase == PH_RDATA) begin
                            if (mack) begin
                                txbyte   <= rd_byte;
                                sda_pull <= ~rd_byte[7];
                            end else begin
                                phase    <= PH_IDLE;
                                sda_pull <= 1'b0;
                            end
                        end else begin
                            sda_pull <= 1'b0;
                        end
                    end else if (phase == PH_RDATA && bitcnt != 4'd0) begin
                        sda_pull <= ~txbyte[3'd7 - bitcnt[2:0]];
                    end
                end
            end
        end
    end

    // R11
    sda_window_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(inhibit) && !$past(evt.start) && !$past(evt.stop) &&
         (sda_pull != $past(sda_pull))) |-> !evt.scl);

    // R6
    inhibit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (!sda_pull && !wr_stb));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (rst)
        ptr <= IDX_TRK);

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (!inhibit && !evt.start && !evt.stop && evt.scl_fall && bitcnt == 4'd8 &&
         phase == PH_WDATA && ptr == IDX_TRK) |=> (ptr == '0));

endmodule

// File: rtl/sercnt_regmap.sv
module sercnt_regmap
    import sercnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] ptr,
    input  logic             wr_stb,
    input  logic [PTR_W-1:0] wr_addr,
    input  logic [7:0]       wr_data,
    input  logic [31:0]      cnt_value,
    output logic [7:0]       rd_byte,
    output logic             cnt_we,
    output logic [1:0]       cnt_sel,
    output logic [7:0]       cnt_wdata,
    output logic             osc_stop,
    output chg_cfg_t         chg
);

    logic [7:0] cnt_bytes [CNT_BYTES];
    logic [7:0] ctrl_q;
    logic [7:0] trk_q;

    for (genvar g = 0; g < CNT_BYTES; g++) begin : g_cnt_split
        assign cnt_bytes[g] = cnt_value[8*g +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            trk_q  <= '0;
        end else if (wr_stb) begin
            if (wr_addr == IDX_CTRL) ctrl_q <= wr_data;
            if (wr_addr == IDX_TRK)  trk_q  <= wr_data;
        end
    end

    assign cnt_we    = wr_stb && (wr_addr < IDX_CTRL);
    assign cnt_sel   = wr_addr[1:0];
    assign cnt_wdata = wr_data;
    assign osc_stop  = ctrl_q[7];
    assign chg       = chg_decode(trk_q);

    always_comb begin
        if (ptr < IDX_CTRL)       rd_byte = cnt_bytes[ptr[1:0]];
        else if (ptr == IDX_CTRL) rd_byte = ctrl_q;
        else                      rd_byte = trk_q;
    end

    // R8
    chg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && wr_addr == IDX_TRK) |=> $stable(chg));

    // R7
    chg_res_chk: assert property (@(posedge clk) disable iff (rst)
        chg.en |-> (chg.res != 2'b00));

endmodule

// File: rtl/sercnt_regif.sv
module sercnt_regif
    import sercnt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_in,
    input  logic        sda_in,
    input  logic        inhibit,
    input  logic [31:0] cnt_value,
    output logic        sda_pull,
    output logic        cnt_we,
    output logic [1:0]  cnt_sel,
    output logic [7:0]  cnt_wdata,
    output logic        osc_stop,
    output logic        chg_en,
    output logic        chg_diode,
    output logic [1:0]  chg_res
);

    bus_evt_t         evt;
    logic [PTR_W-1:0] ptr;
    logic             wr_stb;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;
    logic [7:0]       rd_byte;
    chg_cfg_t         chg;

    sercnt_sync #(.STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .scl_raw (scl_in),
        .sda_raw (sda_in),
        .evt     (evt)
    );

    sercnt_proto u_proto (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .inhibit  (inhibit),
        .rd_byte  (rd_byte),
        .ptr      (ptr),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .sda_pull (sda_pull)
    );

    sercnt_regmap u_regmap (
        .clk       (clk),
        .rst       (rst),
        .ptr       (ptr),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .cnt_value (cnt_value),
        .rd_byte   (rd_byte),
        .cnt_we    (cnt_we),
        .cnt_sel   (cnt_sel),
        .cnt_wdata (cnt_wdata),
        .osc_stop  (osc_stop),
        .chg       (chg)
    );

    assign chg_en    = chg.en;
    assign chg_diode = chg.diode;
    assign chg_res   = chg.res;

endmodule

// File: tb/sim_sercnt_regif.sv
`timescale 1ns/1ps
module sim_sercnt_regif;

    localparam int Q = 20;

    // {charger byte, en, diode, res[1:0]}
    localparam logic [11:0] TRK_VEC [9] = '{
        12'hA59, 12'hA9D, 12'hA6A, 12'hABF, 12'hA10,
        12'hAD0, 12'hA40, 12'h550, 12'hB50
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        inhibit = 1'b0;
    logic [31:0] cnt_model = '0;
    logic        sda_pull;
    logic        cnt_we;
    logic [1:0]  cnt_sel;
    logic [7:0]  cnt_wdata;
    logic        osc_stop;
    logic        chg_en;
    logic        chg_diode;
    logic [1:0]  chg_res;
    logic        sda_line;

    int total = 0;
    int bad = 0;
    int we_cnt = 0;
    int inh_drive = 0;
    bit done = 0;
    logic [7:0] wbuf [8];
    logic [7:0] rbuf [8];

    always #2.5 clk = ~clk;

    assign sda_line = m_sda & ~sda_pull;

    sercnt_regif u0 (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .inhibit   (inhibit),
        .cnt_value (cnt_model),
        .sda_pull  (sda_pull),
        .cnt_we    (cnt_we),
        .cnt_sel   (cnt_sel),
        .cnt_wdata (cnt_wdata),
        .osc_stop  (osc_stop),
        .chg_en    (chg_en),
        .chg_diode (chg_diode),
        .chg_res   (chg_res)
    );

    // counter block model
    always @(posedge clk) begin
        if (cnt_we) begin
            cnt_model[8*cnt_sel +: 8] <= cnt_wdata;
            we_cnt <= we_cnt + 1;
        end
        if (inhibit && sda_pull) inh_drive <= inh_drive + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n = 1);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; wq();
            m_scl = 1'b1;   wq(2);
            m_scl = 1'b0;   wq();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        send_bits(b, 8);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        ack = !sda_line;
        wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 0; i < 8; i++) begin
            wq();
            m_scl = 1'b1; wq();
            b[7-i] = sda_line;
            wq();
            m_scl = 1'b0;
        end
        wq();
        m_sda = mack ? 1'b0 : 1'b1; wq();
        m_scl = 1'b1; wq(2);
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    task automatic do_write(input logic [7:0] p, input int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        bus_start();
        send_byte(8'hD0, a); all_ack &= a;
        send_byte(p, a);     all_ack &= a;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); all_ack &= a;
        end
        bus_stop();
    endtask

    task automatic do_read(input int n, output bit aack);
        bus_start();
        send_byte(8'hD1, aack);
        for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        bit ack;
        int we_before;
        logic [7:0] b;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);

        // reset state (R8, R10, R11)
        chk("R11 sda idle after reset", {31'd0, sda_pull}, 32'd0);
        chk("R10 osc_stop reset", {31'd0, osc_stop}, 32'd0);
        chk("R8 charger outputs reset", {28'd0, chg_en, chg_diode, chg_res}, 32'd0);
        do_write(8'h04, 0, ack);
        chk("R2 pointer-only write acked", {31'd0, ack}, 32'd1);
        do_read(2, ack);
        chk("R1 read address acked", {31'd0, ack}, 32'd1);
        chk("R8 control byte reset value", {24'd0, rbuf[0]}, 32'h00);
        chk("R8 charger byte reset value", {24'd0, rbuf[1]}, 32'h00);

        // burst write of counter bytes (R2, R9)
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        we_before = we_cnt;
        do_write(8'h00, 4, ack);
        chk("R2 burst write all acked", {31'd0, ack}, 32'd1);
        chk("R9 counter bytes least significant first", cnt_model, 32'h44332211);
        chk("R9 one strobe per counter byte", we_cnt - we_before, 32'd4);

        // control byte (R10)
        wbuf[0] = 8'h80;
        do_write(8'h04, 1, ack);
        chk("R10 osc_stop follows bit 7", {31'd0, osc_stop}, 32'd1);

        // read from retained pointer 05h, wrap to 00h, NACK release (R3, R4)
        bus_start();
        send_byte(8'hD1, ack);
        chk("R1 D1h acked", {31'd0, ack}, 32'd1);
        recv_byte(1'b1, rbuf[0]);
        recv_byte(1'b1, rbuf[1]);
        recv_byte(1'b0, rbuf[2]);
        chk("R3 read starts at retained pointer", {24'd0, rbuf[0]}, 32'h00);
        chk("R4 read wraps to 00h", {24'd0, rbuf[1]}, 32'h11);
        chk("R3 burst read continues", {24'd0, rbuf[2]}, 32'h22);
        chk("R3 SDA released after NACK", {31'd0, sda_pull}, 32'd0);
        recv_byte(1'b0, b);
        chk("R3 no drive after NACK until START", {24'd0, b}, 32'hFF);
        bus_stop();

        // foreign address (R1)
        we_before = we_cnt;
        bus_start();
        send_byte(8'hA4, ack);
        chk("R1 foreign address not acked", {31'd0, ack}, 32'd0);
        send_byte(8'h00, ack);
        chk("R1 no ack on bytes after foreign address", {31'd0, ack}, 32'd0);
        bus_stop();
        chk("R1 foreign transfer writes nothing", we_cnt - we_before, 32'd0);

        // charger decode table (R7, R8)
        for (int v = 0; v < 9; v++) begin
            wbuf[0] = TRK_VEC[v][11:4];
            do_write(8'h05, 1, ack);
            chk("R7 charger write acked", {31'd0, ack}, 32'd1);
            chk($sformatf("R7 R8 charger decode of %h", TRK_VEC[v][11:4]),
                {28'd0, chg_en, chg_diode, chg_res}, {28'd0, TRK_VEC[v][3:0]});
        end

        // write wrap from 05h (R4)
        wbuf[0] = 8'hA5; wbuf[1] = 8'h77;
        do_write(8'h05, 2, ack);
        chk("R4 write wraps into counter byte 0", cnt_model, 32'h44332277);
        chk("R7 charger enabled by A5h", {31'd0, chg_en}, 32'd1);

        // out-of-range pointer (R4)
        wbuf[0] = 8'h66;
        do_write(8'h09, 1, ack);
        chk("R4 pointer above 05h loads 00h", cnt_model, 32'h44332266);

        // repeated START mid-byte (R5)
        bus_start();
        send_byte(8'hD0, ack);
        send_byte(8'h04, ack);
        send_bits(8'h00, 3);
        bus_start();
        send_byte(8'hD1, ack);
        chk("R5 address after repeated START acked", {31'd0, ack}, 32'd1);
        recv_byte(1'b0, b);
        bus_stop();
        chk("R5 aborted byte not stored", {24'd0, b}, 32'h80);
        chk("R5 osc_stop kept", {31'd0, osc_stop}, 32'd1);

        // inhibit (R6)
        we_before = we_cnt;
        inhibit = 1'b1;
        wq();
        wbuf[0] = 8'h00; wbuf[1] = 8'h00;
        do_write(8'h03, 2, ack);
        chk("R6 no acknowledge while inhibited", {31'd0, ack}, 32'd0);
        chk("R6 no counter write while inhibited", we_cnt - we_before, 32'd0);
        chk("R6 control untouched while inhibited", {31'd0, osc_stop}, 32'd1);
        chk("R6 SDA never driven while inhibited", inh_drive, 32'd0);
        inhibit = 1'b0;
        wq();
        do_write(8'h03, 0, ack);
        do_read(2, ack);
        chk("R6 counter byte 3 intact", {24'd0, rbuf[0]}, 32'h44);
        chk("R6 control byte intact", {24'd0, rbuf[1]}, 32'h80);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule